// File: doc/BRIEF.md
# Serial Receiver with Break and Framing Classification

This block turns an asynchronous serial line into characters ready for a receive FIFO. It samples the line only on cycles where a sample enable is high. That enable is either sixteen times the bit rate or equal to it, as chosen by a mode input. In the sixteen-times mode a falling edge is taken as a possible start bit and is confirmed by a second look near the middle of that bit. In the one-times mode every enable cycle is a bit sample, and the start bit is not confirmed first. Each character is 5 to 8 data bits, sent least significant bit first. An optional parity bit follows, with even or odd sense, and then one stop bit.

When the stop bit is sampled, the character is sorted into one of three classes: good, framing error, or break. A break is a low stop bit with every data and parity bit also low. The character and its three flags (parity error, framing error, break) are written to the FIFO through a one-cycle push strobe. When the FIFO reports full, the character is dropped and an overrun pulse is raised instead. A break holds the receiver idle until the line has been high for half a bit time. A break that begins partway through a character yields a framing-error character first, then one break character.

Top module: `srx_break_rx`

## Requirements
- R1: In sixteen-times mode (os16_i=1), a low sample on the line starts a check 7 sample ticks later. If the line is high at that check, the start is discarded, nothing is pushed, and the search resumes.
- R2: In sixteen-times mode, once a start bit is confirmed, every later bit is sampled once, 16 ticks after the previous sample. Data bits arrive least significant bit first.
- R3: In one-times mode (os16_i=0), each tick samples one bit. A low sample while idle counts as the start bit, and the next tick samples data bit 0.
- R4: The character length is 5 + len_i (len_i=0 gives 5 bits, 3 gives 8). Data bits that are not used are pushed as zero.
- R5: With par_en_i=1, a parity bit follows the data. par_odd_i=0 expects an even count of ones over data plus parity, and par_odd_i=1 expects an odd count. A mismatch sets push_perr_o.
- R6: A high stop bit pushes the character with framing and break flags clear, and the receiver returns at once to the start search.
- R7: A low stop bit with any data or parity bit high pushes the character with push_ferr_o=1 and push_brk_o=0.
- R8: After a framing error, the line is checked half a bit later (8 ticks, or 1 tick in one-times mode). If it is low, that point is treated as a new start edge. If it is high, the search resumes.
- R9: A low stop bit with all data and parity bits low pushes 0x00 with push_brk_o=1, push_ferr_o=0 and push_perr_o=0, and it sets brk_o.
- R10: While brk_o is high, nothing is pushed. The receiver rearms, and brk_o clears, only after 8 consecutive high ticks (1 in one-times mode). A low tick restarts that count.
- R11: A break that starts mid-character and lasts a further full character time gives two pushes: the damaged character with the framing flag set, then a break character.
- R12: If fifo_full_i is high when a character completes, push_o stays low and overrun_o pulses for one cycle. push_o and overrun_o are never high together.
- R13: The receiver state moves only on cycles with tick_i=1. A low line with no ticks produces neither a push nor a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Sample enable |
| os16_i | input | 1 | 1: sixteen ticks per bit, 0: one tick per bit |
| len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| fifo_full_i | input | 1 | Receive FIFO cannot accept a write |
| push_o | output | 1 | One-cycle FIFO write strobe |
| push_data_o | output | 8 | Character, zero-extended |
| push_perr_o | output | 1 | Parity error flag for the pushed character |
| push_ferr_o | output | 1 | Framing error flag for the pushed character |
| push_brk_o | output | 1 | Break flag for the pushed character |
| overrun_o | output | 1 | One-cycle pulse: a character was dropped |
| brk_o | output | 1 | Line is in a break and the receiver has not rearmed |

## Verification
The hardest case to reach is a break that starts in the middle of a character. The framing-error character, the half-bit recheck, a fresh start confirmation and a whole all-zero character must then follow one another before the break character appears. The bench reaches it by sending a start bit and three high data bits, then holding the line low for many bit times. Both pushes land in a log that is checked in order. The rearm count is tested the same way: a short high run is broken by one low tick, and brk_o must stay set until a full high run follows.

// File: rtl/srxb_pkg.sv
package srxb_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_FEHOLD,
    S_BRKW
  } srx_state_e;

  // number of data bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // bits shifted in from the top; move them down to bit 0
  function automatic logic [CHAR_W-1:0] align_char(input logic [CHAR_W-1:0] sh,
                                                   input logic [1:0] len);
    return sh >> (2'd3 - len);
  endfunction

  function automatic logic parity_bad(input logic [CHAR_W-1:0] d, input logic pbit,
                                      input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction

  function automatic logic all_low(input logic [CHAR_W-1:0] d, input logic pen,
                                   input logic pbit);
    return (d == '0) && !(pen && pbit);
  endfunction

endpackage

// File: rtl/srxb_tick_timer.sv
module srxb_tick_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srxb_shifter.sv
module srxb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] sh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clr)   sh <= '0;
    else if (shift) sh <= {din, sh[W-1:1]};
  end
endmodule

// File: rtl/srx_break_rx.sv
module srx_break_rx
  import srxb_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              os16_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [CHAR_W-1:0] push_data_o,
  output logic              push_perr_o,
  output logic              push_ferr_o,
  output logic              push_brk_o,
  output logic              overrun_o,
  output logic              brk_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LIM_BIT   = CW'(OSR - 1);
  localparam logic [CW-1:0] LIM_HALF  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LIM_START = CW'(OSR / 2 - 2);

  srx_state_e st, nxt;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     lim_bit, lim_half;
  logic [2:0]        nbits;
  logic [CHAR_W-1:0] sh, chr;
  logic              pbit;
  logic              bit_ev, half_ev, start_ev;
  logic              do_shift, do_par, char_done, tmr_clr, enter_data;
  // named events for the checker
  logic              start_rej_w, rearm_w, zero_w;

  assign lim_bit  = os16_i ? LIM_BIT  : '0;
  assign lim_half = os16_i ? LIM_HALF : '0;
  assign bit_ev   = tick_i && (cnt == lim_bit);
  assign half_ev  = tick_i && (cnt == lim_half);
  assign start_ev = tick_i && (cnt == LIM_START);
  assign chr      = align_char(sh, len_i);
  assign zero_w   = all_low(chr, par_en_i, pbit);

  srxb_tick_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .clr(tmr_clr), .cnt(cnt)
  );

  srxb_shifter #(.W(CHAR_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clr(enter_data), .shift(do_shift), .din(rx_i), .sh(sh)
  );

  always_comb begin
    nxt         = st;
    do_shift    = 1'b0;
    do_par      = 1'b0;
    char_done   = 1'b0;
    start_rej_w = 1'b0;
    rearm_w     = 1'b0;
    unique case (st)
      S_IDLE:   if (tick_i && !rx_i) nxt = os16_i ? S_START : S_DATA;
      S_START:  if (start_ev) begin
                  start_rej_w = rx_i;
                  nxt = rx_i ? S_IDLE : S_DATA;
                end
      S_DATA:   if (bit_ev) begin
                  do_shift = 1'b1;
                  if ({1'b0, nbits} == char_bits(len_i) - 4'd1)
                    nxt = par_en_i ? S_PAR : S_STOP;
                end
      S_PAR:    if (bit_ev) begin
                  do_par = 1'b1;
                  nxt = S_STOP;
                end
      S_STOP:   if (bit_ev) begin
                  char_done = 1'b1;
                  nxt = rx_i ? S_IDLE : (zero_w ? S_BRKW : S_FEHOLD);
                end
      S_FEHOLD: if (half_ev) nxt = rx_i ? S_IDLE : (os16_i ? S_START : S_DATA);
      S_BRKW:   if (tick_i && rx_i && cnt == lim_half) begin
                  rearm_w = 1'b1;
                  nxt = S_IDLE;
                end
      default:  nxt = S_IDLE;
    endcase
    enter_data = (nxt == S_DATA) && (st != S_DATA);
    tmr_clr    = (nxt != st) || (st == S_DATA && bit_ev) ||
                 (st == S_BRKW && tick_i && !rx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      nbits <= '0;
      pbit  <= 1'b0;
    end else begin
      st <= nxt;
      if (enter_data) begin
        nbits <= '0;
        pbit  <= 1'b0;
      end else begin
        if (do_shift) nbits <= nbits + 1'b1;
        if (do_par)   pbit  <= rx_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_o      <= 1'b0;
      overrun_o   <= 1'b0;
      push_data_o <= '0;
      push_perr_o <= 1'b0;
      push_ferr_o <= 1'b0;
      push_brk_o  <= 1'b0;
      brk_o       <= 1'b0;
    end else begin
      push_o    <= 1'b0;
      overrun_o <= 1'b0;
      if (char_done) begin
        if (fifo_full_i) overrun_o <= 1'b1;
        else             push_o    <= 1'b1;
        push_data_o <= chr;
        push_ferr_o <= !rx_i && !zero_w;
        push_brk_o  <= !rx_i && zero_w;
        push_perr_o <= par_en_i && parity_bad(chr, pbit, par_odd_i) && !(!rx_i && zero_w);
        if (!rx_i && zero_w) brk_o <= 1'b1;
      end
      if (rearm_w) brk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/srxb_chk.sv
module srxb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       rx_i,
  input logic [1:0] len_i,
  input logic       fifo_full_i,
  input logic       push_o,
  input logic [7:0] push_data_o,
  input logic       push_ferr_o,
  input logic       push_brk_o,
  input logic       overrun_o,
  input logic       brk_o,
  input logic       start_rej_w,
  input logic       rearm_w
);
  p_push_or_ovr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && overrun_o));

  p_ovr_needs_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(fifo_full_i));

  p_brk_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && push_brk_o) |-> (push_data_o == 8'h00 && !push_ferr_o));

  p_quiet_in_brk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_o && $past(brk_o)) |-> !push_o);

  p_rearm_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_w |-> (rx_i && tick_i));

  p_rearm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_w |=> !brk_o);

  p_len5_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && len_i == 2'd0 && $past(len_i) == 2'd0) |-> (push_data_o[7:5] == 3'b000));

  p_reject_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej_w |=> (!push_o && !overrun_o));

  p_no_tick_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> (!push_o && !overrun_o && $stable(brk_o)));
endmodule

bind srx_break_rx srxb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i), .len_i(len_i),
  .fifo_full_i(fifo_full_i), .push_o(push_o), .push_data_o(push_data_o),
  .push_ferr_o(push_ferr_o), .push_brk_o(push_brk_o), .overrun_o(overrun_o),
  .brk_o(brk_o), .start_rej_w(start_rej_w), .rearm_w(rearm_w)
);

// File: tb/srx_break_rx_tb.sv
module srx_break_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_i = 1'b1, tick_i = 1'b1, os16_i = 1'b1;
  logic [1:0] len_i = 2'd3;
  logic par_en_i = 1'b0, par_odd_i = 1'b0, fifo_full_i = 1'b0;
  logic push_o, push_perr_o, push_ferr_o, push_brk_o, overrun_o, brk_o;
  logic [7:0] push_data_o;

  int total = 0, bad = 0, n_push = 0, n_ovr = 0;
  bit finished = 1'b0;
  logic [7:0] lg_d [0:15];
  logic [2:0] lg_f [0:15]; // {perr, ferr, brk}

  always #4 clk = ~clk;

  srx_break_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i), .os16_i(os16_i),
    .len_i(len_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .fifo_full_i(fifo_full_i), .push_o(push_o), .push_data_o(push_data_o),
    .push_perr_o(push_perr_o), .push_ferr_o(push_ferr_o), .push_brk_o(push_brk_o),
    .overrun_o(overrun_o), .brk_o(brk_o)
  );

  always @(negedge clk) begin
    if (rst_n && push_o) begin
      if (n_push < 16) begin
        lg_d[n_push] = push_data_o;
        lg_f[n_push] = {push_perr_o, push_ferr_o, push_brk_o};
      end
      n_push++;
    end
    if (rst_n && overrun_o) n_ovr++;
  end

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    n_push = 0;
    n_ovr  = 0;
  endtask

  task automatic expect_char(input string tag, input int idx, input logic [7:0] d,
                             input logic [2:0] fl);
    chk({tag, " data"}, lg_d[idx] == d, lg_d[idx], d);
    chk({tag, " flags"}, lg_f[idx] == fl, lg_f[idx], fl);
  endtask

  // hold the line at v for n sample ticks, one tick every div clocks
  task automatic hold(input logic v, input int n, input int div);
    rx_i = v;
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      if (div > 1) begin
        tick_i = 1'b0;
        repeat (div - 1) @(negedge clk);
      end
    end
  endtask

  task automatic send_char(input logic [7:0] d, input int nb, input logic pen,
                           input logic pb, input logic stopv, input int tpb, input int div);
    hold(1'b0, tpb, div);
    for (int i = 0; i < nb; i++) hold(d[i], tpb, div);
    if (pen) hold(pb, tpb, div);
    hold(stopv, tpb, div);
  endtask

  task automatic t_reset();
    chk("R12 reset overrun", overrun_o == 1'b0, overrun_o, 0);
    chk("R6 reset push", push_o == 1'b0, push_o, 0);
    chk("R10 reset brk", brk_o == 1'b0, brk_o, 0);
  endtask

  task automatic t_good();
    clear_log();
    send_char(8'hA5, 8, 1'b0, 1'b0, 1'b1, 16, 1);
    send_char(8'h3C, 8, 1'b0, 1'b0, 1'b1, 16, 1);
    hold(1'b1, 32, 1);
    chk("R2 R6 push count", n_push == 2, n_push, 2);
    expect_char("R2 R6 char0", 0, 8'hA5, 3'b000);
    expect_char("R2 R6 char1", 1, 8'h3C, 3'b000);
  endtask

  task automatic t_false_start();
    clear_log();
    hold(1'b0, 3, 1);
    hold(1'b1, 40, 1);
    chk("R1 glitch no push", n_push == 0, n_push, 0);
    send_char(8'h81, 8, 1'b0, 1'b0, 1'b1, 16, 1);
    hold(1'b1, 32, 1);
    chk("R1 after glitch count", n_push == 1, n_push, 1);
    expect_char("R1 after glitch", 0, 8'h81, 3'b000);
  endtask

  task automatic t_len();
    clear_log();
    len_i = 2'd0;
    send_char(8'h1B, 5, 1'b0, 1'b0, 1'b1, 16, 1);
    hold(1'b1, 32, 1);
    len_i = 2'd2;
    send_char(8'h55, 7, 1'b0, 1'b0, 1'b1, 16, 1);
    hold(1'b1, 32, 1);
    len_i = 2'd3;
    chk("R4 count", n_push == 2, n_push, 2);
    expect_char("R4 five bits", 0, 8'h1B, 3'b000);
    expect_char("R4 seven bits", 1, 8'h55, 3'b000);
  endtask

  task automatic t_parity();
    clear_log();
    par_en_i = 1'b1;
    par_odd_i = 1'b0;
    send_char(8'h03, 8, 1'b1, 1'b0, 1'b1, 16, 1); // even, correct
    hold(1'b1, 32, 1);
    send_char(8'h03, 8, 1'b1, 1'b1, 1'b1, 16, 1); // even, wrong
    hold(1'b1, 32, 1);
    par_odd_i = 1'b1;
    send_char(8'h07, 8, 1'b1, 1'b0, 1'b1, 16, 1); // odd, correct
    hold(1'b1, 32, 1);
    par_en_i = 1'b0;
    par_odd_i = 1'b0;
    chk("R5 count", n_push == 3, n_push, 3);
    expect_char("R5 even ok", 0, 8'h03, 3'b000);
    expect_char("R5 even bad", 1, 8'h03, 3'b100);
    expect_char("R5 odd ok", 2, 8'h07, 3'b000);
  endtask

  task automatic t_framing();
    clear_log();
    send_char(8'hA5, 8, 1'b0, 1'b0, 1'b0, 16, 1);
    hold(1'b1, 48, 1);
    chk("R7 count", n_push == 1, n_push, 1);
    expect_char("R7 framing", 0, 8'hA5, 3'b010);
    chk("R7 no brk", brk_o == 1'b0, brk_o, 0);
  endtask

  task automatic t_break();
    clear_log();
    hold(1'b0, 16 * 14, 1);
    chk("R9 count", n_push == 1, n_push, 1);
    expect_char("R9 break", 0, 8'h00, 3'b001);
    chk("R9 brk set", brk_o == 1'b1, brk_o, 1);
    hold(1'b1, 5, 1);
    hold(1'b0, 1, 1);
    hold(1'b1, 5, 1);
    chk("R10 brk held after broken run", brk_o == 1'b1, brk_o, 1);
    hold(1'b1, 12, 1);
    chk("R10 brk cleared", brk_o == 1'b0, brk_o, 0);
    chk("R10 no push in break", n_push == 1, n_push, 1);
    send_char(8'h42, 8, 1'b0, 1'b0, 1'b1, 16, 1);
    hold(1'b1, 32, 1);
    chk("R10 rearmed count", n_push == 2, n_push, 2);
    expect_char("R10 rearmed", 1, 8'h42, 3'b000);
  endtask

  task automatic t_midbreak();
    clear_log();
    hold(1'b0, 16, 1);
    hold(1'b1, 16 * 3, 1);
    hold(1'b0, 16 * 25, 1);
    chk("R11 R8 count", n_push == 2, n_push, 2);
    expect_char("R11 damaged", 0, 8'h07, 3'b010);
    expect_char("R11 R8 break", 1, 8'h00, 3'b001);
    hold(1'b1, 32, 1);
    chk("R11 brk cleared", brk_o == 1'b0, brk_o, 0);
  endtask

  task automatic t_overrun();
    clear_log();
    fifo_full_i = 1'b1;
    send_char(8'h33, 8, 1'b0, 1'b0, 1'b1, 16, 1);
    hold(1'b1, 32, 1);
    fifo_full_i = 1'b0;
    chk("R12 dropped", n_push == 0, n_push, 0);
    chk("R12 overrun pulse", n_ovr == 1, n_ovr, 1);
  endtask

  task automatic t_onex();
    clear_log();
    os16_i = 1'b0;
    hold(1'b1, 4, 4);
    send_char(8'h5A, 8, 1'b0, 1'b0, 1'b1, 1, 4);
    hold(1'b1, 4, 4);
    chk("R3 count", n_push == 1, n_push, 1);
    expect_char("R3 onex", 0, 8'h5A, 3'b000);
    tick_i = 1'b0;
    rx_i = 1'b0;
    repeat (200) @(negedge clk);
    rx_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 no tick no push", n_push == 1, n_push, 1);
    chk("R13 no tick no brk", brk_o == 1'b0, brk_o, 0);
    os16_i = 1'b1;
    hold(1'b1, 16, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    hold(1'b1, 16, 1);
    t_good();
    t_false_start();
    t_len();
    t_parity();
    t_framing();
    t_break();
    t_midbreak();
    t_overrun();
    t_onex();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule